// File: doc/BRIEF.md
# Dual-Clock Video Field Buffer

This block is a byte-wide field memory with two independent ports. One port writes on its own clock and the other reads on an unrelated clock. Each port keeps its own address counter. The counter moves on by one on every enabled clock edge, holds while the port is disabled, and is sent back to the start of the buffer by an explicit, active-low reset pin. The usual use is a field delay or a time-base change. The producer writes a whole field from address zero. The consumer rewinds its own counter and replays the field in order, as many times as it wants.

There are no full or empty flags and no flow control. Each enable pin is a qualifier and gives no back-pressure: every enabled edge moves a byte, and the user keeps the read address far enough behind the write address. Incoming bytes wait in a one-entry staging register before they enter the array. A write-side reset pushes that staged byte into the array. The read output is a registered byte. A separate valid flag stands in for a high-impedance bus, and the data lines read zero while the output is switched off.

Top module: `vfield_fifo`

## Requirements
- R1: On a write-clock rising edge with `wr_en_n` low, the byte on `wr_data` is captured for the current write address, and the write address moves on by one.
- R2: On a write-clock edge with `wr_en_n` high, no byte is captured and the write address keeps its value. The next enabled write lands at that same address.
- R3: On a read-clock rising edge with `rd_en_n` low, the output register loads the byte stored at the current read address, and the read address moves on by one. With `rd_en_n` high, both the read address and the output byte keep their values.
- R4: `wr_rewind_n` and `rd_rewind_n` are sampled on rising edges of their own port's clock. On an enabled edge with the rewind low, that edge uses address 0 (the write stores its byte at 0, or the read loads the byte at 0), and the address then becomes 1.
- R5: A rewind sampled low on an edge where the port is disabled is remembered. It is carried out on the next enabled edge of that port, even if the rewind pin is high by then.
- R6: `rd_oe_n` is sampled on each read-clock edge. After an edge with it high, `rd_valid` is 0 and `rd_data` is 0. After an edge with it low, `rd_valid` is 1 and `rd_data` shows the output register. The read address advances as in R3 whatever the value of `rd_oe_n`.
- R7: A captured byte becomes readable only once it is committed to the array. That happens on the next enabled write edge, or on any write-clock edge where `wr_rewind_n` is low, including a disabled one. Until then, reads of that address return the previous content.
- R8: The address after DEPTH-1 is 0 on both ports (DEPTH = 40 by default, which is not a power of two).
- R9: `arst_n` low clears, at once and without a clock, both addresses, any pending rewind, the staged byte without committing it, the output register and the output-enable state (`rd_valid` = 0, `rd_data` = 0). It does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rewind_n | input | 1 | Write address rewind to 0, active low |
| wr_data | input | DW (8) | Byte to store |
| rd_clk | input | 1 | Read-port clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_rewind_n | input | 1 | Read address rewind to 0, active low |
| rd_data | output | DW (8) | Registered read byte, zero while output is off |
| rd_valid | output | 1 | High while the output is switched on |

## Verification
Two functions can fall on the same edge of one port: a rewind and a data transfer. The bench drives a rewind low together with an active enable. It also leaves a rewind pending from a disabled edge and then enables the port with the rewind pin high. Either way, the byte moved on that edge must belong to address 0, and the bytes that follow must come from addresses 1, 2 and on. On the write side, a commit of the staged byte also falls on the same edge as a rewind. The bench judges this by reading address 0 before and after a rewind-only write edge: it expects the old byte, then the new one.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_ZERO = 2'd2
  } ptr_act_e;
endpackage

// File: rtl/vfb_ptr.sv
module vfb_ptr
  import vfb_pkg::*;
#(
  parameter int DEPTH = 40,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic          rewind,
  output logic [AW-1:0] acc_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          pend_q;
  logic          eff_rewind;
  ptr_act_e      act;
  logic [AW-1:0] next_addr;

  assign eff_rewind = rewind | pend_q;

  always_comb begin
    if (!en)             act = PTR_HOLD;
    else if (eff_rewind) act = PTR_ZERO;
    else                 act = PTR_STEP;
  end

  always_comb begin
    acc_addr = (act == PTR_ZERO) ? '0 : addr_q;
    if (acc_addr == LAST) next_addr = '0;
    else                  next_addr = acc_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q <= '0;
      pend_q <= 1'b0;
    end else begin
      case (act)
        PTR_HOLD: pend_q <= pend_q | rewind;
        PTR_STEP, PTR_ZERO: begin
          addr_q <= next_addr;
          pend_q <= 1'b0;
        end
        default: pend_q <= pend_q;
      endcase
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> $stable(addr_q)); // R2
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    addr_q <= LAST); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!arst_n)
    (en && !eff_rewind && addr_q == LAST) |=> addr_q == '0); // R8
  AST_REWIND_DEFER: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && rewind) |=> (!en || acc_addr == '0)); // R5
  AST_REWIND_NOW: assert property (@(posedge clk) disable iff (!arst_n)
    (en && rewind) |=> (addr_q == ((DEPTH > 1) ? AW'(1) : '0))); // R4
endmodule

// File: rtl/vfb_mem.sv
module vfb_mem #(
  parameter int DEPTH = 40,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_byte
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (wr_en) cells[wr_addr] <= wr_byte;
  end

  assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/vfb_wr_stage.sv
module vfb_wr_stage #(
  parameter int DEPTH = 40,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic          rewind,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] din,
  output logic          commit_en,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_byte
);
  logic          stg_v;
  logic [AW-1:0] stg_a;
  logic [DW-1:0] stg_d;

  assign commit_en   = stg_v & (en | rewind);
  assign commit_addr = stg_a;
  assign commit_byte = stg_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_v <= 1'b0;
      stg_a <= '0;
      stg_d <= '0;
    end else if (en) begin
      stg_v <= 1'b1;
      stg_a <= acc_addr;
      stg_d <= din;
    end else if (rewind) begin
      stg_v <= 1'b0;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && rewind) |=> !stg_v); // R7
  AST_STAGE_FILLS: assert property (@(posedge clk) disable iff (!arst_n)
    en |=> (stg_v && stg_d == $past(din))); // R1
  AST_HOLD_STAGE: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && !rewind) |=> $stable(stg_v)); // R2
endmodule

// File: rtl/vfb_rd_stage.sv
module vfb_rd_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic          oe,
  input  logic [DW-1:0] mem_byte,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);
  logic [DW-1:0] out_q;
  logic          oe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= oe;
      if (en) out_q <= mem_byte;
    end
  end

  assign dout     = oe_q ? out_q : '0;
  assign dout_vld = oe_q;

  AST_OE_ON: assert property (@(posedge clk) disable iff (!arst_n)
    oe |=> dout_vld); // R6
  AST_OE_OFF_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    !oe |=> (dout == '0 && !dout_vld)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && oe && $past(oe)) |=> $stable(dout)); // R3
endmodule

// File: rtl/vfield_fifo.sv
module vfield_fifo #(
  parameter int DEPTH = 40,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk,
  input  logic          arst_n,
  input  logic          wr_en_n,
  input  logic          wr_rewind_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en_n,
  input  logic          rd_oe_n,
  input  logic          rd_rewind_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [AW-1:0] w_addr, r_addr, c_addr;
  logic [DW-1:0] c_byte, m_byte;
  logic          c_en;

  vfb_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(wr_clk), .arst_n(arst_n), .en(!wr_en_n), .rewind(!wr_rewind_n),
    .acc_addr(w_addr)
  );

  vfb_wr_stage #(.DEPTH(DEPTH), .DW(DW)) u_wstg (
    .clk(wr_clk), .arst_n(arst_n), .en(!wr_en_n), .rewind(!wr_rewind_n),
    .acc_addr(w_addr), .din(wr_data),
    .commit_en(c_en), .commit_addr(c_addr), .commit_byte(c_byte)
  );

  vfb_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .wclk(wr_clk), .wr_en(c_en), .wr_addr(c_addr), .wr_byte(c_byte),
    .rd_addr(r_addr), .rd_byte(m_byte)
  );

  vfb_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(rd_clk), .arst_n(arst_n), .en(!rd_en_n), .rewind(!rd_rewind_n),
    .acc_addr(r_addr)
  );

  vfb_rd_stage #(.DW(DW)) u_rstg (
    .clk(rd_clk), .arst_n(arst_n), .en(!rd_en_n), .oe(!rd_oe_n),
    .mem_byte(m_byte), .dout(rd_data), .dout_vld(rd_valid)
  );

  AST_RESET_QUIET: assert property (@(posedge rd_clk)
    !arst_n |-> (!rd_valid && rd_data == '0)); // R9
endmodule

// File: tb/vfield_fifo_tb_top.sv
module vfield_fifo_tb_top;
  localparam int D = 40;

  logic wr_clk = 0, rd_clk = 0, arst_n = 0;
  logic wr_en_n = 1, wr_rewind_n = 1, rd_en_n = 1, rd_oe_n = 1, rd_rewind_n = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_valid;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  vfield_fifo #(.DEPTH(D), .DW(8)) dut_i (
    .wr_clk(wr_clk), .arst_n(arst_n), .wr_en_n(wr_en_n), .wr_rewind_n(wr_rewind_n),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_oe_n(rd_oe_n),
    .rd_rewind_n(rd_rewind_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0, errors = 0;
  logic [7:0] ref_m [D];
  int wp = 0, rp = 0;
  bit wpend = 0, rpend = 0, sv = 0;
  int sa = 0;
  logic [7:0] sd = 0, exp_d = 0;
  bit exp_v = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] want, bit gv, bit wv);
    checks++;
    if (got !== want || gv !== wv) begin
      errors++;
      $display("FAIL %s: data=%02h valid=%0b expected data=%02h valid=%0b",
               tag, got, gv, want, wv);
    end
  endtask

  task automatic wr(bit en_n, bit rw_n, logic [7:0] d);
    bit eff;
    @(negedge wr_clk);
    wr_en_n = en_n; wr_rewind_n = rw_n; wr_data = d;
    @(posedge wr_clk);
    eff = !rw_n || wpend;
    if (!en_n) begin
      if (sv) ref_m[sa] = sd;
      sa = eff ? 0 : wp; sv = 1; sd = d;
      wp = (sa + 1) % D; wpend = 0;
    end else if (!rw_n) begin
      if (sv) ref_m[sa] = sd;
      sv = 0; wpend = 1;
    end
    @(negedge wr_clk);
    wr_en_n = 1; wr_rewind_n = 1;
  endtask

  task automatic rd(bit en_n, bit rw_n, bit oe_n, string tag);
    bit eff;
    int a;
    @(negedge rd_clk);
    rd_en_n = en_n; rd_rewind_n = rw_n; rd_oe_n = oe_n;
    @(posedge rd_clk);
    eff = !rw_n || rpend;
    if (!en_n) begin
      a = eff ? 0 : rp; exp_d = ref_m[a];
      rp = (a + 1) % D; rpend = 0;
    end else if (!rw_n) rpend = 1;
    exp_v = !oe_n;
    @(negedge rd_clk);
    check(tag, rd_data, exp_v ? exp_d : 8'h00, rd_valid, exp_v);
    rd_en_n = 1; rd_rewind_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23;
    check("R9 reset state", rd_data, 8'h00, rd_valid, 1'b0);
    arst_n = 1;
    // R1 R4 R2 R8: field from address 0, idle slots, one extra byte wraps onto 0
    for (int i = 0; i <= D; i++) begin
      if (i % 7 == 3) wr(1'b1, 1'b1, 8'hEE);
      wr(1'b0, (i == 0) ? 1'b0 : 1'b1, pat(i));
    end
    wr(1'b1, 1'b0, 8'h77); // R7 flush while disabled, rewind becomes pending
    // R4 rewind with enable on same edge, then sweep with holds, oe off, wrap
    rd(1'b0, 1'b0, 1'b0, "R4 read rewind loads address 0");
    for (int k = 1; k <= D + 6; k++) begin
      if (k % 9 == 4)                    rd(1'b1, 1'b1, 1'b0, "R3 hold while disabled");
      else if (k % 11 == 5 || k % 11 == 6) rd(1'b0, 1'b1, 1'b1, "R6 output off, address advances");
      else if (k >= D)                    rd(1'b0, 1'b1, 1'b0, "R8 read address wrap");
      else                                rd(1'b0, 1'b1, 1'b0, "R1 stored bytes in order");
    end
    // R5 deferred write rewind taken by the next enabled write
    wr(1'b0, 1'b1, 8'hA5);
    wr(1'b0, 1'b1, 8'h5A);
    wr(1'b1, 1'b0, 8'h00);
    // R5 deferred read rewind
    rd(1'b1, 1'b0, 1'b0, "R5 disabled rewind holds output");
    rd(1'b0, 1'b1, 1'b0, "R5 deferred read rewind address 0");
    rd(1'b0, 1'b1, 1'b0, "R5 after deferred rewind address 1");
    rd(1'b0, 1'b1, 1'b0, "R5 after deferred rewind address 2");
    // R7 staged byte invisible until committed
    wr(1'b0, 1'b1, 8'h3C);
    rd(1'b0, 1'b0, 1'b0, "R7 staged byte not yet visible");
    wr(1'b1, 1'b0, 8'h00);
    rd(1'b0, 1'b0, 1'b0, "R7 committed by write rewind");
    rd(1'b0, 1'b1, 1'b1, "R6 output off");
    rd(1'b0, 1'b1, 1'b0, "R6 output back on");
    // R9 asynchronous clear mid run
    @(negedge rd_clk);
    arst_n = 0;
    #1;
    check("R9 clear drops output", rd_data, 8'h00, rd_valid, 1'b0);
    rp = 0; rpend = 0; wp = 0; wpend = 0; sv = 0; exp_d = 0;
    #20;
    arst_n = 1;
    rd(1'b0, 1'b1, 1'b0, "R9 read address cleared to 0");
    rd(1'b0, 1'b1, 1'b0, "R9 then address 1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule